// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for an LCD panel: a horizontal and a vertical sync pulse, a display-enable strobe and the running pixel and line positions. Every line and every frame opens with its sync pulse at count 0. The sync end, the display start and the total are absolute positions within the line or the frame, and a separate width or height sets the size of the active window. The host drives the timing values as static inputs. The block copies them into a shadow set only at a frame boundary, or while timing is stopped, so a change made part way through a frame never tears the picture.

A 2-bit polarity input sets the active level of each sync output. The block also provides a copy of the current line number and level flags for the vsync interval and the vertical blanking interval. It raises single-cycle pulses at the frame start, at the first displayed pixel and on a programmable match line. In normal use the match line is set to the first line after active video, so the pulse can serve as an end-of-picture interrupt. A timing-enable input parks both counters at position 0 and holds every output inactive while it is low.

Top module: `lcd_raster_timing`

## Requirements
- R1: While `rst` is high, and on the first output cycle after it, every output is 0: `hsync`, `vsync`, `de`, `cur_line`, `vsync_flag`, `vblank_flag`, `frame_start`, `disp_start`, `line_hit`.
- R2: A line lasts `h_total` cycles, with pixel positions 0 to `h_total`-1, or 1 cycle if `h_total` is below 2. `hsync` is active at positions below `h_sync_end`. Outputs appear one clock after the position that produces them.
- R3: A frame lasts `v_total` lines, with line positions 0 to `v_total`-1, or 1 line if `v_total` is below 2. `vsync` is active and `vsync_flag` is 1 on lines below `v_sync_end`.
- R4: `pol[0]` sets the active level of `hsync` and `pol[1]` sets the active level of `vsync` (1 means active-high, 0 means active-low). A sync output sits at the opposite level whenever it is not active. `pol` is not shadowed and takes effect on the next cycle.
- R5: `de` is 1 only when the pixel position lies in [`h_disp_start`, `h_disp_start`+`h_active`) and the line lies in [`v_disp_start`, `v_disp_start`+`v_active`).
- R6: `vblank_flag` is 1 when the line is below `v_disp_start` or above `v_disp_start`+`v_active`. The line equal to `v_disp_start`+`v_active` is therefore neither blanked nor displayed.
- R7: `cur_line` reports the line position, with the same one-clock latency as the other outputs.
- R8: `frame_start` pulses for one cycle at position (0,0). `disp_start` pulses for one cycle at pixel `h_disp_start` of line `v_disp_start`.
- R9: `line_hit` pulses for one cycle at pixel 0 of line `v_match`.
- R10: The timing values are captured only in a cycle that ends a frame, or while `en` is low. A change made mid-frame leaves the rest of that frame unchanged.
- R11: While `en` is low, both counters are held at 0. During that time `de`, the flags, the pulses and `cur_line` are 0, and each sync output sits at its inactive level. After `en` rises, timing restarts from position (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Timing enable |
| pol | input | 2 | Sync polarity: bit 0 for hsync, bit 1 for vsync, 1 = active-high |
| h_sync_end | input | 16 | Pixel position where hsync ends |
| h_disp_start | input | 16 | First displayed pixel position |
| h_active | input | 16 | Displayed pixels per line |
| h_total | input | 16 | Pixel positions per line |
| v_sync_end | input | 16 | Line where vsync ends |
| v_disp_start | input | 16 | First displayed line |
| v_active | input | 16 | Displayed lines per frame |
| v_total | input | 16 | Lines per frame |
| v_match | input | 16 | Line that raises line_hit |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| cur_line | output | 16 | Current line position |
| vsync_flag | output | 1 | Vsync interval level |
| vblank_flag | output | 1 | Vertical blanking level |
| frame_start | output | 1 | Frame start pulse |
| disp_start | output | 1 | First displayed pixel pulse |
| line_hit | output | 1 | Match line pulse |

## Verification
A wrong pixel or line count shows up at the ports within one line as a shifted `hsync` edge or `de` window. A wrong line count is visible on `cur_line` at the next line boundary. Shadow registers loaded at the wrong moment change the line length or the window positions before the frame ends, which the first mismatching output reveals. A polarity or enable fault shows on the very next cycle as a sync level that is wrong or an output that should be inactive but is not.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int unsigned CW = 16;

  typedef struct packed {
    logic [CW-1:0] sync_end;
    logic [CW-1:0] disp_start;
    logic [CW-1:0] active;
    logic [CW-1:0] total;
  } axis_cfg_t;
endpackage

// File: rtl/lcdt_axis_ctr.sv
module lcdt_axis_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] total,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic last;

  assign last = ({1'b0, cnt} + 1'b1) >= {1'b0, total};
  assign wrap = run & step & last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  // R2 R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (total != '0) |-> (cnt < total));
endmodule

// File: rtl/lcdt_shadow.sv
module lcdt_shadow
  import lcdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  axis_cfg_t     h_in,
  input  axis_cfg_t     v_in,
  input  logic [CW-1:0] match_in,
  output axis_cfg_t     h_cfg,
  output axis_cfg_t     v_cfg,
  output logic [CW-1:0] match_cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      h_cfg     <= '0;
      v_cfg     <= '0;
      match_cfg <= '0;
    end else if (load) begin
      h_cfg     <= h_in;
      v_cfg     <= v_in;
      match_cfg <= match_in;
    end
  end

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(h_cfg) && $stable(v_cfg) && $stable(match_cfg)));
endmodule

// File: rtl/lcdt_axis_win.sv
module lcdt_axis_win
  import lcdt_pkg::*;
(
  input  logic [CW-1:0] cnt,
  input  axis_cfg_t     cfg,
  output logic          in_sync,
  output logic          in_disp,
  output logic          at_ds,
  output logic          blank
);
  logic [CW:0] disp_end;

  assign disp_end = {1'b0, cfg.disp_start} + {1'b0, cfg.active};
  assign in_sync  = cnt < cfg.sync_end;
  assign at_ds    = cnt == cfg.disp_start;
  assign in_disp  = (cnt >= cfg.disp_start) && ({1'b0, cnt} < disp_end);
  assign blank    = (cnt < cfg.disp_start) || ({1'b0, cnt} > disp_end);
endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
  import lcdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [1:0]    pol,
  input  logic [CW-1:0] h_sync_end,
  input  logic [CW-1:0] h_disp_start,
  input  logic [CW-1:0] h_active,
  input  logic [CW-1:0] h_total,
  input  logic [CW-1:0] v_sync_end,
  input  logic [CW-1:0] v_disp_start,
  input  logic [CW-1:0] v_active,
  input  logic [CW-1:0] v_total,
  input  logic [CW-1:0] v_match,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] cur_line,
  output logic          vsync_flag,
  output logic          vblank_flag,
  output logic          frame_start,
  output logic          disp_start,
  output logic          line_hit
);
  localparam int unsigned NAX = 2;  // axis 0 = pixels, axis 1 = lines

  axis_cfg_t     h_in, v_in, h_cfg, v_cfg;
  logic [CW-1:0] match_cfg;
  logic          h_wrap, v_wrap, shadow_load;
  logic [CW-1:0] cnt_a [NAX];
  axis_cfg_t     cfg_a [NAX];
  logic [NAX-1:0] sync_a, disp_a, ds_a, blank_a;

  assign h_in = '{sync_end: h_sync_end, disp_start: h_disp_start,
                  active: h_active, total: h_total};
  assign v_in = '{sync_end: v_sync_end, disp_start: v_disp_start,
                  active: v_active, total: v_total};

  assign shadow_load = !en || v_wrap;

  lcdt_shadow u_shadow (
    .clk(clk), .rst(rst), .load(shadow_load),
    .h_in(h_in), .v_in(v_in), .match_in(v_match),
    .h_cfg(h_cfg), .v_cfg(v_cfg), .match_cfg(match_cfg)
  );

  lcdt_axis_ctr #(.W(CW)) u_hctr (
    .clk(clk), .rst(rst), .run(en), .step(1'b1),
    .total(h_cfg.total), .cnt(cnt_a[0]), .wrap(h_wrap)
  );

  lcdt_axis_ctr #(.W(CW)) u_vctr (
    .clk(clk), .rst(rst), .run(en), .step(h_wrap),
    .total(v_cfg.total), .cnt(cnt_a[1]), .wrap(v_wrap)
  );

  assign cfg_a[0] = h_cfg;
  assign cfg_a[1] = v_cfg;

  for (genvar a = 0; a < NAX; a++) begin : g_win
    lcdt_axis_win u_win (
      .cnt(cnt_a[a]), .cfg(cfg_a[a]),
      .in_sync(sync_a[a]), .in_disp(disp_a[a]),
      .at_ds(ds_a[a]), .blank(blank_a[a])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync <= 1'b0; vsync <= 1'b0; de <= 1'b0; cur_line <= '0;
      vsync_flag <= 1'b0; vblank_flag <= 1'b0;
      frame_start <= 1'b0; disp_start <= 1'b0; line_hit <= 1'b0;
    end else if (!en) begin
      hsync <= ~pol[0]; vsync <= ~pol[1]; de <= 1'b0; cur_line <= '0;
      vsync_flag <= 1'b0; vblank_flag <= 1'b0;
      frame_start <= 1'b0; disp_start <= 1'b0; line_hit <= 1'b0;
    end else begin
      hsync       <= sync_a[0] ? pol[0] : ~pol[0];
      vsync       <= sync_a[1] ? pol[1] : ~pol[1];
      de          <= disp_a[0] & disp_a[1];
      cur_line    <= cnt_a[1];
      vsync_flag  <= sync_a[1];
      vblank_flag <= blank_a[1];
      frame_start <= (cnt_a[0] == '0) && (cnt_a[1] == '0);
      disp_start  <= ds_a[0] & ds_a[1];
      line_hit    <= (cnt_a[0] == '0) && (cnt_a[1] == match_cfg);
    end
  end

  // R6
  de_blank_chk: assert property (@(posedge clk) disable iff (rst)
    de |-> !vblank_flag);

  // R5
  hwin_excl_chk: assert property (@(posedge clk) disable iff (rst)
    disp_a[0] |-> !blank_a[0]);

  // R8
  fstart_line_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (cur_line == '0));

  // R11
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!de && !vblank_flag && !vsync_flag && !line_hit &&
             (cur_line == '0) && (hsync == ~$past(pol[0]))));
endmodule

// File: tb/test_lcd_raster_timing.sv
module test_lcd_raster_timing;
  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0;
  logic [1:0] pol = 2'b11;
  logic [15:0] hse = 0, hds = 0, hact = 0, ht = 0;
  logic [15:0] vse = 0, vds = 0, vact = 0, vt = 0, vm = 0;
  logic hsync, vsync, de, vsync_flag, vblank_flag, frame_start, disp_start, line_hit;
  logic [15:0] cur_line;

  int checks = 0, errors = 0;
  bit done = 0;
  string phase_tag = "";

  always #10 clk = ~clk;

  lcd_raster_timing i_lcd_raster_timing (
    .clk(clk), .rst(rst), .en(en), .pol(pol),
    .h_sync_end(hse), .h_disp_start(hds), .h_active(hact), .h_total(ht),
    .v_sync_end(vse), .v_disp_start(vds), .v_active(vact), .v_total(vt),
    .v_match(vm),
    .hsync(hsync), .vsync(vsync), .de(de), .cur_line(cur_line),
    .vsync_flag(vsync_flag), .vblank_flag(vblank_flag),
    .frame_start(frame_start), .disp_start(disp_start), .line_hit(line_hit)
  );

  typedef struct {
    int hs, vs, de, line, vf, vb, fs, ds, lh;
    string tag;
  } item_t;

  item_t q[$];

  // model state
  int mh = 0, mv = 0;
  int s_hse = 0, s_hds = 0, s_hact = 0, s_ht = 0;
  int s_vse = 0, s_vds = 0, s_vact = 0, s_vt = 0, s_vm = 0;

  task automatic load_shadow();
    s_hse = hse; s_hds = hds; s_hact = hact; s_ht = ht;
    s_vse = vse; s_vds = vds; s_vact = vact; s_vt = vt; s_vm = vm;
  endtask

  // driver: one clock; expected result pushed right after the edge
  task automatic cycle();
    item_t it;
    bit hwr;
    @(posedge clk);
    it.tag = phase_tag;
    if (rst) begin
      it = '{0, 0, 0, 0, 0, 0, 0, 0, 0, phase_tag};
      mh = 0; mv = 0;
      s_hse = 0; s_hds = 0; s_hact = 0; s_ht = 0;
      s_vse = 0; s_vds = 0; s_vact = 0; s_vt = 0; s_vm = 0;
    end else if (!en) begin
      it = '{int'(!pol[0]), int'(!pol[1]), 0, 0, 0, 0, 0, 0, 0, phase_tag};
      mh = 0; mv = 0;
      load_shadow();
    end else begin
      it.hs   = (mh < s_hse) ? int'(pol[0]) : int'(!pol[0]);
      it.vs   = (mv < s_vse) ? int'(pol[1]) : int'(!pol[1]);
      it.de   = int'(mh >= s_hds && mh < s_hds + s_hact &&
                     mv >= s_vds && mv < s_vds + s_vact);
      it.line = mv;
      it.vf   = int'(mv < s_vse);
      it.vb   = int'(mv < s_vds || mv > s_vds + s_vact);
      it.fs   = int'(mh == 0 && mv == 0);
      it.ds   = int'(mh == s_hds && mv == s_vds);
      it.lh   = int'(mh == 0 && mv == s_vm);
      hwr = (mh + 1 >= s_ht);
      if (hwr) begin
        mh = 0;
        if (mv + 1 >= s_vt) begin
          mv = 0;
          load_shadow();
        end else mv++;
      end else mh++;
    end
    q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic chk(string tag, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, name, act, exp, $time);
    end
  endtask

  function automatic string pick(string t, string dflt);
    return (t == "") ? dflt : t;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      chk(pick(e.tag, "R2"), "hsync", int'(hsync), e.hs);
      chk(pick(e.tag, "R3"), "vsync", int'(vsync), e.vs);
      chk(pick(e.tag, "R5"), "de", int'(de), e.de);
      chk(pick(e.tag, "R7"), "cur_line", int'(cur_line), e.line);
      chk(pick(e.tag, "R3"), "vsync_flag", int'(vsync_flag), e.vf);
      chk(pick(e.tag, "R6"), "vblank_flag", int'(vblank_flag), e.vb);
      chk(pick(e.tag, "R8"), "frame_start", int'(frame_start), e.fs);
      chk(pick(e.tag, "R8"), "disp_start", int'(disp_start), e.ds);
      chk(pick(e.tag, "R9"), "line_hit", int'(line_hit), e.lh);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    phase_tag = "R1";
    #1;
    run(3);
    rst = 1'b0;
    // R11 idle outputs with en low
    phase_tag = "R11";
    hse = 2; hds = 4; hact = 6; ht = 13;
    vse = 1; vds = 3; vact = 4; vt = 10; vm = 7;
    pol = 2'b11;
    run(4);
    // R2 R3 R5 R6 R7 R8 R9 main timing, two frames
    phase_tag = "";
    en = 1'b1;
    run(260);
    // R4 polarity variants
    phase_tag = "R4";
    pol = 2'b01; run(130);
    pol = 2'b10; run(130);
    pol = 2'b00; run(40);
    pol = 2'b11;
    // R10 mid-frame reprogram, takes effect at the next frame start
    phase_tag = "R10";
    run(25);
    hse = 1; hds = 2; hact = 3; ht = 7;
    vse = 2; vds = 2; vact = 3; vt = 8; vm = 0;
    run(260);
    // R9 match line 0 coincides with frame start under config B
    phase_tag = "";
    run(112);
    // R11 stop mid-frame, then restart at (0,0)
    phase_tag = "R11";
    run(17);
    en = 1'b0; run(5);
    en = 1'b1; run(80);
    // R2 totals below 2 give one-cycle lines
    phase_tag = "R2";
    en = 1'b0; ht = 1; vt = 3; hse = 1; hds = 0; hact = 1;
    vse = 1; vds = 1; vact = 1; vm = 2;
    run(2);
    en = 1'b1; run(20);
    run(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule